// File: doc/BRIEF.md
# Shift-add BCD-to-binary converter

This block turns a four-digit packed decimal word into the equal unsigned binary number. Each decimal digit is weighted by adding shifted copies of its own nibble: the hundreds and tens weights are sums of powers of two. The thousands weight is 1024 less 16 less 8. The two subtracted copies are produced by inverting the zero-extended thousands nibble and injecting the matching carry-in ones. All shifted terms go into a single balanced adder tree whose sum is kept modulo 2^14. The path is purely combinational: no clock, no register and no constant multiplier.

A producer places the packed digits on `bcd_in` (thousands in bits 15:12, hundreds in 11:8, tens in 7:4, units in 3:0) and raises `in_valid`. The binary result appears on `bin_out` in the same cycle. A digit code above nine raises `invalid_bcd` and drops `out_valid`. In that case the value on `bin_out` has no defined meaning.

Top module: `bcd2bin_shiftadd`

## Requirements
- R1: With in_valid=1 and every nibble 0..9, bin_out equals 1000*bcd_in[15:12] + 100*bcd_in[11:8] + 10*bcd_in[7:4] + bcd_in[3:0].
- R2: bin_out is 14 bits wide; the input 9999 gives 14'h270F and no valid input gives more than 9999.
- R3: A thousands digit d alone (other nibbles zero) gives exactly d*1000, formed as 1024d - 16d - 8d by two's complement terms.
- R4: The hundreds, tens and units digits alone give 100d, 10d and d respectively.
- R5: invalid_bcd is 1 exactly when at least one nibble holds 10..15, regardless of in_valid.
- R6: out_valid equals in_valid AND NOT invalid_bcd.
- R7: With in_valid=0, bin_out is 0 whatever bcd_in holds.
- R8: The outputs follow a new input within the same cycle, with no clock or storage in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_in | input | 16 | Packed decimal word, thousands nibble most significant |
| in_valid | input | 1 | Qualifies bcd_in; bin_out is 0 when low |
| bin_out | output | 14 | Unsigned binary equivalent of bcd_in |
| out_valid | output | 1 | in_valid with all digits legal |
| invalid_bcd | output | 1 | Some nibble holds a code above nine |

## Verification
Whenever the inputs change, the embedded assertions check three things. The three thousands terms and their injected ones must net to exactly 1000 times the digit. The tree root must equal a flat sum of every operand. For legal digits the result must match the decimal formula and stay at or below 9999. Only the bench scenarios can show the rest: the full sweep of all ten thousand legal words, the raising of the illegal-digit flag for every illegal code in every position, the effect of the qualifier on `bin_out` and `out_valid`, and the same-cycle response.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
    localparam int NIB_W    = 4;
    localparam int DIGITS   = 4;
    localparam int IN_W     = NIB_W * DIGITS;
    localparam int OUT_W    = 14;
    localparam int NUM_OPS  = 10;
    localparam int MAX_DIG  = 9;
    localparam int MAX_VAL  = 9999;

    typedef logic [NIB_W-1:0]                nib_t;
    typedef logic [OUT_W-1:0]                word_t;
    typedef logic [NUM_OPS-1:0][OUT_W-1:0]   ops_t;

    typedef struct packed {
        word_t bin;
        logic  ok;
        logic  bad;
    } conv_t;

    // zero-extend a nibble to word width and shift it left
    function automatic word_t shl_nib(input nib_t v, input int sh);
        word_t w;
        w = word_t'(v);
        return word_t'(w << sh);
    endfunction
endpackage

// File: rtl/bcd2bin_terms.sv
module bcd2bin_terms
    import bcd2bin_pkg::*;
(
    input  logic [IN_W-1:0] bcd_in,
    output ops_t            ops
);
    localparam int SH_HI   = 10;
    localparam int SH_SUBA = 4;
    localparam int SH_SUBB = 3;
    localparam word_t INJECT = word_t'((1 << SH_SUBA) + (1 << SH_SUBB));

    nib_t th, hu, te, un;
    logic [NIB_W:0] inv5;
    word_t inv_ext;

    always_comb begin
        th = bcd_in[4*NIB_W-1:3*NIB_W];
        hu = bcd_in[3*NIB_W-1:2*NIB_W];
        te = bcd_in[2*NIB_W-1:NIB_W];
        un = bcd_in[NIB_W-1:0];
        // inverted zero-extended thousands nibble, sign extended
        inv5    = ~{1'b0, th};
        inv_ext = {{(OUT_W-NIB_W-1){inv5[NIB_W]}}, inv5};
        ops[0] = shl_nib(th, SH_HI);
        ops[1] = word_t'(inv_ext << SH_SUBA);
        ops[2] = word_t'(inv_ext << SH_SUBB);
        ops[3] = shl_nib(hu, 6);
        ops[4] = shl_nib(hu, 5);
        ops[5] = shl_nib(hu, 2);
        ops[6] = shl_nib(te, 3);
        ops[7] = shl_nib(te, 1);
        ops[8] = word_t'(un);
        ops[9] = INJECT;
    end

    word_t th_net;
    always_comb begin
        th_net = ops[0] + ops[1] + ops[2] + ops[9];
        if (!$isunknown(bcd_in)) begin
            // R3: thousands terms net to digit times 1000
            a_r3_thousands_weight: assert (int'(th_net) == int'(th) * 1000)
                else $error("thousands terms net %0d for digit %0d", th_net, th);
        end
    end
endmodule

// File: rtl/bcd2bin_tree.sv
module bcd2bin_tree #(
    parameter int N = 10,
    parameter int W = 14
) (
    input  logic [N-1:0][W-1:0] ops,
    output logic [W-1:0]        sum
);
    localparam int LEV = $clog2(N);
    localparam int P   = 1 << LEV;

    for (genvar l = 0; l <= LEV; l++) begin : g_lvl
        logic [W-1:0] v [P >> l];
        for (genvar k = 0; k < (P >> l); k++) begin : g_node
            if (l == 0) begin : g_leaf
                if (k < N) begin : g_op
                    assign v[k] = ops[k];
                end else begin : g_pad
                    assign v[k] = '0;
                end
            end else begin : g_add
                assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
            end
        end
    end

    assign sum = g_lvl[LEV].v[0];

    logic [W-1:0] flat;
    always_comb begin
        flat = '0;
        for (int i = 0; i < N; i++) flat = flat + ops[i];
        if (!$isunknown(ops)) begin
            // R1: tree root equals flat operand sum
            a_r1_tree_sum: assert (sum == flat)
                else $error("tree root %0h flat sum %0h", sum, flat);
        end
    end
endmodule

// File: rtl/bcd2bin_digchk.sv
module bcd2bin_digchk #(
    parameter int DIGITS = 4,
    parameter int NIB_W  = 4,
    parameter int MAXD   = 9
) (
    input  logic [DIGITS*NIB_W-1:0] bcd_in,
    output logic                    bad
);
    logic [DIGITS-1:0] over;
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign over[g] = (bcd_in[g*NIB_W +: NIB_W] > NIB_W'(MAXD));
    end
    assign bad = |over;
endmodule

// File: rtl/bcd2bin_shiftadd.sv
module bcd2bin_shiftadd
    import bcd2bin_pkg::*;
(
    input  logic [IN_W-1:0]  bcd_in,
    input  logic             in_valid,
    output logic [OUT_W-1:0] bin_out,
    output logic             out_valid,
    output logic             invalid_bcd
);
    ops_t  ops;
    word_t raw_sum;
    logic  bad;
    conv_t res_d;

    bcd2bin_terms u_terms (
        .bcd_in (bcd_in),
        .ops    (ops)
    );

    bcd2bin_tree #(.N(NUM_OPS), .W(OUT_W)) u_tree (
        .ops (ops),
        .sum (raw_sum)
    );

    bcd2bin_digchk #(.DIGITS(DIGITS), .NIB_W(NIB_W), .MAXD(MAX_DIG)) u_chk (
        .bcd_in (bcd_in),
        .bad    (bad)
    );

    always_comb begin
        res_d.bad = bad;
        res_d.ok  = in_valid & ~bad;
        res_d.bin = in_valid ? raw_sum : '0;
    end

    assign bin_out     = res_d.bin;
    assign out_valid   = res_d.ok;
    assign invalid_bcd = res_d.bad;

    int ref_val;
    always_comb begin
        ref_val = int'(bcd_in[15:12]) * 1000 + int'(bcd_in[11:8]) * 100
                + int'(bcd_in[7:4]) * 10 + int'(bcd_in[3:0]);
        if (!$isunknown({bcd_in, in_valid}) && in_valid && !invalid_bcd) begin
            // R1: decimal formula
            a_r1_value: assert (int'(bin_out) == ref_val)
                else $error("bin_out %0d expected %0d", bin_out, ref_val);
            // R2: legal result within 9999
            a_r2_range: assert (int'(bin_out) <= MAX_VAL)
                else $error("bin_out %0d above range", bin_out);
        end
    end
endmodule

// File: tb/sim_bcd2bin_shiftadd.sv
module sim_bcd2bin_shiftadd;
    logic        clk = 1'b0;
    logic [15:0] bcd_in = '0;
    logic        in_valid = 1'b0;
    logic [13:0] bin_out;
    logic        out_valid;
    logic        invalid_bcd;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bcd2bin_shiftadd u0 (
        .bcd_in      (bcd_in),
        .in_valid    (in_valid),
        .bin_out     (bin_out),
        .out_valid   (out_valid),
        .invalid_bcd (invalid_bcd)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s bcd=%h v=%b actual=%0d expected=%0d",
                     tag, bcd_in, in_valid, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] b, input logic v);
        @(negedge clk);
        bcd_in   = b;
        in_valid = v;
        #2;
    endtask

    function automatic logic [15:0] pack(input int a, input int b, input int c, input int d);
        return {4'(a), 4'(b), 4'(c), 4'(d)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // idle state
        drive(16'h0000, 1'b0);
        check("R7 idle bin_out", int'(bin_out), 0);
        check("R6 idle out_valid", int'(out_valid), 0);
        check("R5 idle invalid_bcd", int'(invalid_bcd), 0);

        // R3 and R4: single digits
        for (int d = 0; d < 10; d++) begin
            drive(pack(d, 0, 0, 0), 1'b1);
            check("R3 thousands", int'(bin_out), d * 1000);
            drive(pack(0, d, 0, 0), 1'b1);
            check("R4 hundreds", int'(bin_out), d * 100);
            drive(pack(0, 0, d, 0), 1'b1);
            check("R4 tens", int'(bin_out), d * 10);
            drive(pack(0, 0, 0, d), 1'b1);
            check("R4 units", int'(bin_out), d);
        end

        // R2: maximum
        drive(16'h9999, 1'b1);
        check("R2 max value", int'(bin_out), 16'h270F);
        check("R6 max out_valid", int'(out_valid), 1);

        // R8: same-cycle response on back-to-back words
        @(negedge clk);
        bcd_in = 16'h1234; in_valid = 1'b1;
        #1;
        check("R8 immediate", int'(bin_out), 1234);
        bcd_in = 16'h8765;
        #1;
        check("R8 immediate change", int'(bin_out), 8765);

        // R1: full sweep of legal words
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 10; c++)
                    for (int d = 0; d < 10; d++) begin
                        drive(pack(a, b, c, d), 1'b1);
                        check("R1 value", int'(bin_out), a*1000 + b*100 + c*10 + d);
                        if (a == 5 && b == 5 && c == 5) begin
                            check("R5 legal flag", int'(invalid_bcd), 0);
                            check("R6 legal out_valid", int'(out_valid), 1);
                        end
                    end

        // R5 and R6: illegal codes in each position
        for (int p = 0; p < 4; p++)
            for (int code = 10; code < 16; code++) begin
                logic [15:0] w;
                w = 16'h3333;
                w[p*4 +: 4] = 4'(code);
                drive(w, 1'b1);
                check("R5 illegal flag", int'(invalid_bcd), 1);
                check("R6 illegal out_valid", int'(out_valid), 0);
                drive(w, 1'b0);
                check("R5 illegal flag unqualified", int'(invalid_bcd), 1);
                check("R7 unqualified bin_out", int'(bin_out), 0);
            end

        // R7: legal word without qualifier
        drive(16'h4567, 1'b0);
        check("R7 legal unqualified", int'(bin_out), 0);
        check("R6 legal unqualified", int'(out_valid), 0);
        drive(16'h4567, 1'b1);
        check("R1 after requalify", int'(bin_out), 4567);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule